// File: doc/BRIEF.md
# Auxiliary GPIO Port with Interrupt Pins

This block is an eight-pin general-purpose I/O port that a host controls through simple register read and write strobes. Three host registers set each pin's direction, hold the values the port drives, and return the current pin levels. Each pin has its own tri-state drive enable. Every pin level first passes through a synchronizer. The host then reads it back, and the interrupt logic watches it too.

The two highest pins can also act as active-low, level-sensitive interrupt inputs. A mask register gates each of them, and a pending status register latches each request. Some pins can be handed to a secondary function chosen by the operating mode. Pins 0 to 2 are claimed in the network-side mode. Pins 7, 5 and 4 are claimed by individual select bits. A claimed pin's direction is forced by that function, and host writes to its direction bit have no effect. When the claim is dropped, the stored direction applies again.

The mode and the secondary-function selects are static configuration inputs. The secondary functions themselves sit outside this block.

Top module: `aux_gpio_port`

## Requirements
- R1: After synchronous reset, the direction register reads 0xFF (all inputs), the transmit register reads 0x00, the mask register reads 0x03 (both interrupt pins masked), and the status register reads 0x00. No pin is driven and `irq` is low.
- R2: A direction bit of 0 on an unclaimed pin asserts its `gpio_drive` bit. `gpio_out` carries the transmit-register bit. A direction bit of 1 leaves the pin undriven.
- R3: A read of the receive register returns the synchronized level of every pin, including pins configured as outputs, once the level has been stable for two clock cycles.
- R4: The register addresses are: direction 0x3E (read/write), receive 0x3F (read-only; writes change no register), transmit 0x3D, mask 0x3C (bit 1 = pin 7, bit 0 = pin 6), and status 0x3B (bit 1 = pin 7, bit 0 = pin 6). `rdata` is valid in the cycle after `rd_en`. A read of any other address returns 0.
- R5: For a claimed pin, a direction write leaves the stored bit unchanged. The direction readback shows the matching `fn_dir` bit (1 = input), and `gpio_drive` stays low for that pin.
- R6: `net_mode` = 1 claims pins 0 to 2. `sec_en` claims only pins 7, 5 and 4; its other bits have no effect.
- R7: When a claim is removed, the readback, the drive enables and the interrupt eligibility all follow the stored direction bit again.
- R8: A status bit sets when its pin is low after synchronization, its mask bit is 0, its direction bit is 1, and the pin is unclaimed. `irq` is high while any status bit is set.
- R9: A masked pin never sets its status bit, but its level still shows in the receive register.
- R10: An interrupt pin configured as an output, or claimed, never sets its status bit.
- R11: A status read returns the pending bits and clears them in the same cycle. A bit whose condition persists sets again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| gpio_out | output | 8 | Values for pads driven by the port |
| gpio_drive | output | 8 | Per-pin drive enable, 1 = port drives the pad |
| net_mode | input | 1 | Network-side mode, claims pins 0 to 2 |
| sec_en | input | 8 | Secondary-function select per pin (pins 7, 5, 4 honoured) |
| fn_dir | input | 8 | Direction forced by secondary functions, 1 = input |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The direction logic is exercised under three claim patterns: no claim, network mode only, and network mode with every select bit set. These show whether the readback merges forced and stored bits correctly, and whether select bits on unclaimable pins leak through. A direction write made during a claim, followed by a release, separates "write ignored" from "write stored but hidden". Interrupts are driven by a low level on each pin in turn. Each case is then repeated with the pin masked, configured as an output, or claimed. This distinguishes the mask, direction and claim gates. Reads of the status register while the level is still low, and after it returns high, tell clear-on-read apart from level re-arming.

// File: rtl/aux_gpio_pkg.sv
package aux_gpio_pkg;

  localparam int unsigned DEF_STAT_ADDR = 'h3B;
  localparam int unsigned DEF_MASK_ADDR = 'h3C;
  localparam int unsigned DEF_TX_ADDR   = 'h3D;
  localparam int unsigned DEF_OE_ADDR   = 'h3E;
  localparam int unsigned DEF_RX_ADDR   = 'h3F;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OE,
    SEL_RX,
    SEL_TX,
    SEL_MASK,
    SEL_STAT
  } reg_sel_e;

endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/aux_dir_ctrl.sv
module aux_dir_ctrl #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] claimed,
  input  logic [NPINS-1:0] fn_dir,
  output logic [NPINS-1:0] dir_view,
  output logic [NPINS-1:0] drive,
  output logic [NPINS-1:0] in_avail
);

  logic [NPINS-1:0] oe_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                    oe_q[i] <= 1'b1;
      else if (wr && !claimed[i]) oe_q[i] <= wdata[i];
    end
    assign dir_view[i] = claimed[i] ? fn_dir[i] : oe_q[i];
    assign drive[i]    = !claimed[i] && !oe_q[i];
    assign in_avail[i] = !claimed[i] && oe_q[i];
  end

endmodule

// File: rtl/aux_irq_unit.sv
module aux_irq_unit #(
  parameter int unsigned NIRQ = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] lvl,
  input  logic [NIRQ-1:0] avail,
  input  logic [NIRQ-1:0] mask,
  input  logic            clr,
  output logic [NIRQ-1:0] pend
);

  for (genvar k = 0; k < NIRQ; k++) begin : g_src
    logic req;
    assign req = !lvl[k] && avail[k] && !mask[k];
    always_ff @(posedge clk) begin
      if (rst)      pend[k] <= 1'b0;
      else if (clr) pend[k] <= 1'b0;
      else if (req) pend[k] <= 1'b1;
    end
  end

endmodule

// File: rtl/aux_gpio_port.sv
module aux_gpio_port
  import aux_gpio_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned NIRQ        = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OE_ADDR     = DEF_OE_ADDR,
  parameter int unsigned RX_ADDR     = DEF_RX_ADDR,
  parameter int unsigned TX_ADDR     = DEF_TX_ADDR,
  parameter int unsigned MASK_ADDR   = DEF_MASK_ADDR,
  parameter int unsigned STAT_ADDR   = DEF_STAT_ADDR,
  parameter logic [NPINS-1:0] SEC_PINS = NPINS'(8'hB0),
  parameter logic [NPINS-1:0] RSV_PINS = NPINS'(8'h07),
  parameter logic [NIRQ-1:0]  MASK_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  gpio_out,
  output logic [NPINS-1:0]  gpio_drive,
  input  logic              net_mode,
  input  logic [NPINS-1:0]  sec_en,
  input  logic [NPINS-1:0]  fn_dir,
  output logic              irq
);

  localparam int unsigned IRQ_LO = NPINS - NIRQ;

  reg_sel_e         sel;
  logic [NPINS-1:0] claimed;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] dir_view;
  logic [NPINS-1:0] in_avail;
  logic [NPINS-1:0] tx_q;
  logic [NIRQ-1:0]  mask_q;
  logic [NIRQ-1:0]  pend_q;
  logic [NPINS-1:0] rd_mux;
  logic [NPINS-1:0] rdata_q;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OE_ADDR))   sel = SEL_OE;
    else if (addr == ADDR_W'(RX_ADDR))   sel = SEL_RX;
    else if (addr == ADDR_W'(TX_ADDR))   sel = SEL_TX;
    else if (addr == ADDR_W'(MASK_ADDR)) sel = SEL_MASK;
    else if (addr == ADDR_W'(STAT_ADDR)) sel = SEL_STAT;
  end

  assign claimed = (sec_en & SEC_PINS) | ({NPINS{net_mode}} & RSV_PINS);

  aux_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  aux_dir_ctrl #(.NPINS(NPINS)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr_en && sel == SEL_OE),
    .wdata    (wdata),
    .claimed  (claimed),
    .fn_dir   (fn_dir),
    .dir_view (dir_view),
    .drive    (gpio_drive),
    .in_avail (in_avail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      mask_q <= MASK_RST;
    end else if (wr_en) begin
      if (sel == SEL_TX)   tx_q   <= wdata;
      if (sel == SEL_MASK) mask_q <= wdata[NIRQ-1:0];
    end
  end

  aux_irq_unit #(.NIRQ(NIRQ)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .lvl   (pin_sync[NPINS-1:IRQ_LO]),
    .avail (in_avail[NPINS-1:IRQ_LO]),
    .mask  (mask_q),
    .clr   (rd_en && sel == SEL_STAT),
    .pend  (pend_q)
  );

  always_comb begin
    case (sel)
      SEL_OE:   rd_mux = dir_view;
      SEL_RX:   rd_mux = pin_sync;
      SEL_TX:   rd_mux = tx_q;
      SEL_MASK: rd_mux = NPINS'(mask_q);
      SEL_STAT: rd_mux = NPINS'(pend_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign gpio_out = tx_q;
  assign irq      = |pend_q;

endmodule

// File: rtl/aux_gpio_port_chk.sv
module aux_gpio_port_chk #(
  parameter int unsigned NPINS     = 8,
  parameter int unsigned NIRQ      = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned OE_ADDR   = 'h3E,
  parameter int unsigned STAT_ADDR = 'h3B,
  parameter logic [NPINS-1:0] SEC_PINS = NPINS'(8'hB0),
  parameter logic [NPINS-1:0] RSV_PINS = NPINS'(8'h07)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  wdata,
  input logic              net_mode,
  input logic [NPINS-1:0]  sec_en,
  input logic [NPINS-1:0]  gpio_drive,
  input logic [NIRQ-1:0]   mask_q,
  input logic [NIRQ-1:0]   pend_q
);

  localparam int unsigned IRQ_LO = NPINS - NIRQ;

  logic [NPINS-1:0] claimed_c;
  assign claimed_c = (sec_en & SEC_PINS) | ({NPINS{net_mode}} & RSV_PINS);

  // R5: a claimed pin is never driven by the port
  assert_no_claimed_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (gpio_drive & claimed_c) == '0);

  // R2: a direction write sets drive enables of pins unclaimed around it
  assert_oe_write_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OE_ADDR)) |=>
      ((gpio_drive ^ ~$past(wdata)) & ~claimed_c & ~$past(claimed_c)) == '0);

  // R11: a status read leaves nothing pending in the next cycle
  assert_status_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(STAT_ADDR)) |=> pend_q == '0);

  for (genvar k = 0; k < NIRQ; k++) begin : g_irq
    // R9: a pending bit only rises while its mask bit was clear
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[k]) |-> !$past(mask_q[k]));
    // R10: a pending bit never rises for a pin the port was driving
    assert_output_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[k]) |-> !$past(gpio_drive[IRQ_LO + k]));
  end

endmodule

bind aux_gpio_port aux_gpio_port_chk #(
  .NPINS(NPINS), .NIRQ(NIRQ), .ADDR_W(ADDR_W),
  .OE_ADDR(OE_ADDR), .STAT_ADDR(STAT_ADDR),
  .SEC_PINS(SEC_PINS), .RSV_PINS(RSV_PINS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .net_mode(net_mode), .sec_en(sec_en),
  .gpio_drive(gpio_drive), .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/aux_gpio_port_test.sv
`timescale 1ns/1ps
module aux_gpio_port_test;

  localparam logic [7:0] A_STAT = 8'h3B, A_MASK = 8'h3C, A_TX = 8'h3D,
                         A_OE = 8'h3E, A_RX = 8'h3F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [7:0] pin_in = 8'hFF, gpio_out, gpio_drive;
  logic       net_mode = 1'b0;
  logic [7:0] sec_en = '0, fn_dir = '0;
  logic       irq;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  aux_gpio_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .gpio_out(gpio_out),
    .gpio_drive(gpio_drive), .net_mode(net_mode), .sec_en(sec_en),
    .fn_dir(fn_dir), .irq(irq)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check(gpio_drive, 8'h00, "R1 drive after reset");
    check({7'b0, irq}, 8'h00, "R1 irq after reset");
    rd(A_OE, v);   check(v, 8'hFF, "R1 direction reset");
    rd(A_TX, v);   check(v, 8'h00, "R1 transmit reset");
    rd(A_MASK, v); check(v, 8'h03, "R1 mask reset");
    rd(A_STAT, v); check(v, 8'h00, "R1 status reset");
  endtask

  task automatic t_direction;
    logic [7:0] v;
    wr(A_TX, 8'hA5);
    wr(A_OE, 8'h0F);
    check(gpio_drive, 8'hF0, "R2 drive enables");
    check(gpio_out, 8'hA5, "R2 driven values");
    rd(A_OE, v); check(v, 8'h0F, "R4 direction readback");
    rd(A_TX, v); check(v, 8'hA5, "R4 transmit readback");
  endtask

  task automatic t_receive;
    logic [7:0] v;
    pin_in = 8'h3C; tick(3);
    rd(A_RX, v); check(v, 8'h3C, "R3 receive levels");
    wr(A_RX, 8'h00);
    rd(A_OE, v); check(v, 8'h0F, "R4 receive write leaves direction");
    rd(A_TX, v); check(v, 8'hA5, "R4 receive write leaves transmit");
    rd(A_RX, v); check(v, 8'h3C, "R4 receive read-only");
    rd(8'h10, v); check(v, 8'h00, "R4 unmapped read");
    pin_in = 8'hC3; tick(3);
    rd(A_RX, v); check(v, 8'hC3, "R3 levels on output pins");
    pin_in = 8'hFF; tick(3);
  endtask

  task automatic t_claim;
    logic [7:0] v;
    fn_dir = 8'h55;
    net_mode = 1'b1; tick(1);
    rd(A_OE, v); check(v, 8'h0D, "R6 network mode readback");
    check(gpio_drive, 8'hF0, "R6 network mode drive");
    sec_en = 8'hFF; tick(1);
    rd(A_OE, v); check(v, 8'h1D, "R6 select bits on pins 7,5,4 only");
    check(gpio_drive, 8'h40, "R5 claimed pins undriven");
    wr(A_OE, 8'h00);
    rd(A_OE, v); check(v, 8'h15, "R5 write to claimed bits ignored");
    check(gpio_drive, 8'h48, "R5 unclaimed bits written");
    sec_en = 8'h00; net_mode = 1'b0; tick(1);
    rd(A_OE, v); check(v, 8'h07, "R7 stored direction after release");
    check(gpio_drive, 8'hF8, "R7 drive after release");
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(A_OE, 8'hFF);
    wr(A_MASK, 8'h00);
    pin_in = 8'hFF; tick(4);
    check({7'b0, irq}, 8'h00, "R8 no irq with pins high");
    pin_in = 8'h7F; tick(4);
    check({7'b0, irq}, 8'h01, "R8 irq on pin 7 low");
    rd(A_STAT, v); check(v, 8'h02, "R8 status bit 1 for pin 7");
    check({7'b0, irq}, 8'h00, "R11 cleared by status read");
    tick(1);
    check({7'b0, irq}, 8'h01, "R11 re-set while level low");
    pin_in = 8'hFF; tick(4);
    check({7'b0, irq}, 8'h01, "R11 pending held after level rises");
    rd(A_STAT, v); check(v, 8'h02, "R11 status returned");
    tick(1);
    check({7'b0, irq}, 8'h00, "R11 stays clear after rise");
    pin_in = 8'hBF; tick(4);
    rd(A_STAT, v); check(v, 8'h01, "R8 status bit 0 for pin 6");
    pin_in = 8'hFF; tick(4);
    rd(A_STAT, v);
    rd(A_STAT, v); check(v, 8'h00, "R11 status empty");
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(A_MASK, 8'h01);
    pin_in = 8'hBF; tick(5);
    check({7'b0, irq}, 8'h00, "R9 masked pin 6 no irq");
    rd(A_RX, v); check(v, 8'hBF, "R9 masked level visible");
    rd(A_STAT, v); check(v, 8'h00, "R9 masked status clear");
    pin_in = 8'hFF; tick(4);
  endtask

  task automatic t_output;
    logic [7:0] v;
    wr(A_MASK, 8'h00);
    wr(A_OE, 8'h7F);
    pin_in = 8'h7F; tick(5);
    check({7'b0, irq}, 8'h00, "R10 output pin 7 no irq");
    rd(A_STAT, v); check(v, 8'h00, "R10 output pin status clear");
    wr(A_OE, 8'hFF);
    sec_en = 8'h80; tick(5);
    check({7'b0, irq}, 8'h00, "R10 claimed pin 7 no irq");
    sec_en = 8'h00; tick(4);
    check({7'b0, irq}, 8'h01, "R7 irq eligible after release");
    pin_in = 8'hFF; tick(4);
    rd(A_STAT, v);
  endtask

  initial begin
    #(8 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_direction();
    t_receive();
    t_claim();
    t_irq();
    t_mask();
    t_output();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule